// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Hour Format

This block keeps time of day and the calendar in packed BCD. It holds seconds, minutes, hours, weekday, day of month, month and a two-digit year, plus a century flag in the month register. A time-base pulse `tick` arrives `PRESCALE` times per second. An internal prescaler divides it down, and each completed second ripples a carry through the fields. A control bit chooses how hours are kept: a 24-hour count, or a 12-hour count with a PM flag.

A serial front end reaches the block through a register write port addressed by a 4-bit index. It can also hold `freeze` high while it reads or writes several registers as one consistent snapshot. A second that completes while the counters are frozen is not lost. It is kept as one pending carry and applied once the freeze drops. Two sticky status flags are kept in a control register: oscillator-stopped, which is set by reset, and voltage-low, which is set by an input. The host clears either flag by writing a zero to its bit.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 0x12 (12 AM in 12-hour mode), weekday 0, day 01, month 0x01 (century 0), year 00, control-1 0x00 and control-2 0x10 (oscillator-stopped set, voltage-low clear).
- R2: Seconds advance by one after every `PRESCALE` ticks. They count in BCD from 00 to 59 and wrap to 00, and the wrap carries into minutes, which count from 00 to 59 in the same way and carry into hours.
- R3: When control-1 bit 5 is 1 (24-hour mode), hours count in BCD from 00 to 23, and the wrap from 23 to 00 carries into the day.
- R4: When control-1 bit 5 is 0 (12-hour mode), hours bits 4:0 count in BCD through 12, 01, ..., 11. Hours bit 5 is the PM flag and toggles on the step from 11 to 12. The step from 11 PM (0x31) to 12 AM (0x12) carries into the day, and noon reads 0x32.
- R5: The day counts from 01 to the length of the month and then wraps to 01 with a carry into the month. April, June, September and November have 30 days, February has 28, and the rest have 31. February has 29 when the BCD year is divisible by 4.
- R6: Month bits 4:0 count from 01 to 12 and then wrap to 01 with a carry into the year. The year counts from 00 to 99 and wraps to 00, and at that wrap the century flag in month bit 7 toggles.
- R7: The weekday (bits 2:0) advances with every day carry and wraps from 6 to 0.
- R8: A write with `wr_en` high stores `wr_data` masked into the addressed register. The addresses and masks are: 0 seconds (0x7F), 1 minutes (0x7F), 2 hours (0x3F), 3 weekday (0x07), 4 day (0x3F), 5 month (0x9F), 6 year (0xFF) and 14 control-1 (0xFF). A write to any other address, apart from 15, changes nothing.
- R9: While `freeze` is high, and during any write cycle, no counter advances. A second that completes in that time is held as one pending carry, and the counters advance once on the first cycle with neither `freeze` nor a write.
- R10: A write to the seconds register clears the prescaler and discards any pending carry.
- R11: Control-2 bit 4 (oscillator-stopped) and bit 6 (voltage-low) are sticky. Voltage-low sets whenever `low_volt` is high. A write to address 15 clears each flag whose data bit is 0 and never sets a flag. All other control-2 bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse, `PRESCALE` per second, one cycle wide |
| freeze | input | 1 | Holds all counters while high |
| low_volt | input | 1 | Supply-low indication, sets the voltage-low flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index for the write |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, bit 5 = PM in 12-hour mode |
| wday_o | output | 8 | Weekday 0 to 6 |
| day_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month BCD in bits 4:0, century flag in bit 7 |
| year_o | output | 8 | Year 00 to 99, BCD |
| ctl1_o | output | 8 | Control-1, bit 5 selects 24-hour mode |
| ctl2_o | output | 8 | Control-2 status flags |
| osc_stop_o | output | 1 | Oscillator-stopped flag |
| volt_low_o | output | 1 | Voltage-low flag |

## Verification
The embedded properties assume that the host writes only valid BCD that lies within each field's range. They also assume a non-zero day, and that the hours value is rewritten to match the format after a mode change. The range and PM-flip checks depend on these inputs. The bench stays within these limits: every time it loads a calendar vector, it writes control-1 first and seconds last, and every value it writes is a legal field value. The one masking test uses out-of-range upper bits only where the masked result is still legal.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int PRESCALE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       freeze,
  input  logic       low_volt,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic [7:0] ctl1_o,
  output logic [7:0] ctl2_o,
  output logic       osc_stop_o,
  output logic       volt_low_o
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt;
  logic          pend;
  logic [7:0]    sec, mnt, hour, day, mon, year, ctl1;
  logic [2:0]    wday;
  logic          osc, vlow;
  logic [7:0]    n_sec, n_mnt, n_hour, n_day, n_mon, n_year;
  logic [2:0]    n_wday;

  wire sec_roll = tick && (pcnt == PLAST);
  wire hold     = freeze | wr_en;
  wire adv      = !hold && (pend || sec_roll);
  wire wr_sec   = wr_en && (wr_addr == 4'd0);
  wire mode24   = ctl1[5];

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic leap(input logic [7:0] y);
    if (y[4]) leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [4:0] m, input logic lp);
    case (m)
      5'h02:                      month_len = lp ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_len = 8'h30;
      default:                    month_len = 8'h31;
    endcase
  endfunction

  always_comb begin
    logic c_min, c_hr, c_day, c_mon, c_yr;
    logic [7:0] h8;
    n_sec = sec; n_mnt = mnt; n_hour = hour; n_wday = wday;
    n_day = day; n_mon = mon; n_year = year;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    h8 = 8'h00;
    if (adv) begin
      c_min = (sec >= 8'h59);
      n_sec = c_min ? 8'h00 : bcd_inc(sec);
      if (c_min) begin
        c_hr  = (mnt >= 8'h59);
        n_mnt = c_hr ? 8'h00 : bcd_inc(mnt);
      end
      if (c_hr) begin
        if (mode24) begin
          c_day  = (hour >= 8'h23);
          n_hour = c_day ? 8'h00 : bcd_inc(hour);
        end else if (hour[4:0] >= 5'h12) begin
          n_hour = {2'b00, hour[5], 5'h01};
        end else if (hour[4:0] == 5'h11) begin
          n_hour = {2'b00, ~hour[5], 5'h12};
          c_day  = hour[5];
        end else begin
          h8     = bcd_inc({3'b000, hour[4:0]});
          n_hour = {2'b00, hour[5], h8[4:0]};
        end
      end
      if (c_day) begin
        n_wday = (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
        c_mon  = (day >= month_len(mon[4:0], leap(year)));
        n_day  = c_mon ? 8'h01 : bcd_inc(day);
      end
      if (c_mon) begin
        c_yr  = (mon[4:0] >= 5'h12);
        h8    = bcd_inc({3'b000, mon[4:0]});
        n_mon = {mon[7], 2'b00, c_yr ? 5'h01 : h8[4:0]};
      end
      if (c_yr) begin
        n_year = (year >= 8'h99) ? 8'h00 : bcd_inc(year);
        if (year >= 8'h99) n_mon[7] = ~mon[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      pend <= 1'b0;
    end else begin
      if (wr_sec)     pcnt <= '0;
      else if (tick)  pcnt <= sec_roll ? '0 : pcnt + 1'b1;
      if (wr_sec)     pend <= 1'b0;
      else if (hold)  pend <= pend | sec_roll;
      else            pend <= pend & sec_roll;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 8'h00; mnt <= 8'h00; hour <= 8'h12; wday <= 3'd0;
      day <= 8'h01; mon <= 8'h01; year <= 8'h00; ctl1 <= 8'h00;
      osc <= 1'b1;  vlow <= 1'b0;
    end else begin
      sec <= n_sec; mnt <= n_mnt; hour <= n_hour; wday <= n_wday;
      day <= n_day; mon <= n_mon; year <= n_year;
      vlow <= vlow | low_volt;
      if (wr_en) begin
        case (wr_addr)
          4'd0:  sec  <= wr_data & 8'h7F;
          4'd1:  mnt  <= wr_data & 8'h7F;
          4'd2:  hour <= wr_data & 8'h3F;
          4'd3:  wday <= wr_data[2:0];
          4'd4:  day  <= wr_data & 8'h3F;
          4'd5:  mon  <= wr_data & 8'h9F;
          4'd6:  year <= wr_data;
          4'd14: ctl1 <= wr_data;
          4'd15: begin
            osc  <= osc & wr_data[4];
            vlow <= (vlow & wr_data[6]) | low_volt;
          end
          default: ;
        endcase
      end
    end
  end

  assign sec_o      = sec;
  assign min_o      = mnt;
  assign hour_o     = hour;
  assign wday_o     = {5'b00000, wday};
  assign day_o      = day;
  assign mon_o      = mon;
  assign year_o     = year;
  assign ctl1_o     = ctl1;
  assign ctl2_o     = {1'b0, vlow, 1'b0, osc, 4'b0000};
  assign osc_stop_o = osc;
  assign volt_low_o = vlow;

  p_sec_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[3:0] <= 4'd9) && (sec <= 8'h59));

  p_pm_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !mode24 && sec == 8'h59 && mnt == 8'h59 && hour[4:0] == 5'h11)
    |=> (hour[5] != $past(hour[5])) && (hour[4:0] == 5'h12));

  p_day_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    day != 8'h00);

  p_century_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && year == 8'h99) |=> (year != 8'h00) || (mon[7] != $past(mon[7])));

  p_wday_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wday <= 3'd6);

  p_frozen_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> $stable(sec) && $stable(mnt) && $stable(day));

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd15 && !wr_data[4]) |=> !osc_stop_o);

endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE = 2;
  localparam int NV = 18;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, freeze = 1'b0, low_volt = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, day_o, mon_o, year_o, ctl1_o, ctl2_o;
  logic osc_stop_o, volt_low_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_core #(.PRESCALE(PRESCALE)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze), .low_volt(low_volt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o), .day_o(day_o),
    .mon_o(mon_o), .year_o(year_o), .ctl1_o(ctl1_o), .ctl2_o(ctl2_o),
    .osc_stop_o(osc_stop_o), .volt_low_o(volt_low_o));

  // {ctl1, in: sec min hour wday day mon year, out: sec min hour wday day mon year}
  localparam logic [119:0] VEC [NV] = '{
    {8'h20, 8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h24, 8'h01,8'h00,8'h00,8'h00,8'h01,8'h01,8'h24}, // R2
    {8'h20, 8'h59,8'h59,8'h23,8'h06,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h00,8'h01,8'h81,8'h00}, // R6 R7
    {8'h20, 8'h59,8'h59,8'h10,8'h02,8'h05,8'h07,8'h30, 8'h00,8'h00,8'h11,8'h02,8'h05,8'h07,8'h30}, // R3
    {8'h00, 8'h59,8'h59,8'h11,8'h01,8'h10,8'h03,8'h25, 8'h00,8'h00,8'h32,8'h01,8'h10,8'h03,8'h25}, // R4 noon
    {8'h00, 8'h59,8'h59,8'h31,8'h03,8'h15,8'h06,8'h25, 8'h00,8'h00,8'h12,8'h04,8'h16,8'h06,8'h25}, // R4 midnight
    {8'h00, 8'h59,8'h59,8'h32,8'h00,8'h01,8'h01,8'h25, 8'h00,8'h00,8'h21,8'h00,8'h01,8'h01,8'h25}, // R4
    {8'h00, 8'h59,8'h59,8'h12,8'h00,8'h01,8'h01,8'h25, 8'h00,8'h00,8'h01,8'h00,8'h01,8'h01,8'h25}, // R4
    {8'h00, 8'h59,8'h59,8'h09,8'h00,8'h01,8'h01,8'h25, 8'h00,8'h00,8'h10,8'h00,8'h01,8'h01,8'h25}, // R4
    {8'h20, 8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h03,8'h29,8'h02,8'h24}, // R5 leap
    {8'h20, 8'h59,8'h59,8'h23,8'h03,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h24}, // R5
    {8'h20, 8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h23}, // R5
    {8'h20, 8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h12, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h12}, // R5
    {8'h20, 8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h10, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h10}, // R5
    {8'h20, 8'h59,8'h59,8'h23,8'h04,8'h30,8'h04,8'h25, 8'h00,8'h00,8'h00,8'h05,8'h01,8'h05,8'h25}, // R5
    {8'h20, 8'h59,8'h59,8'h23,8'h04,8'h30,8'h01,8'h25, 8'h00,8'h00,8'h00,8'h05,8'h31,8'h01,8'h25}, // R5
    {8'h20, 8'h59,8'h59,8'h23,8'h05,8'h31,8'h92,8'h99, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h01,8'h00}, // R6
    {8'h20, 8'h59,8'h59,8'h23,8'h00,8'h30,8'h09,8'h25, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h10,8'h25}, // R5
    {8'h20, 8'h59,8'h58,8'h05,8'h00,8'h10,8'h10,8'h25, 8'h00,8'h59,8'h05,8'h00,8'h10,8'h10,8'h25}  // R2
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic logic [63:0] tod();
    return {8'h00, sec_o, min_o, hour_o, wday_o, day_o, mon_o, year_o};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    logic [7:0] s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1 time", tod(), {8'h00, 8'h00,8'h00,8'h12,8'h00,8'h01,8'h01,8'h00});
    chk("R1 ctl", {48'd0, ctl1_o, ctl2_o}, {48'd0, 8'h00, 8'h10});

    // R11 flags
    @(negedge clk); low_volt = 1'b1;
    @(negedge clk); low_volt = 1'b0;
    @(negedge clk);
    chk("R11 vlow sticky", {56'd0, ctl2_o}, {56'd0, 8'h50});
    wr(4'd15, 8'h40);
    chk("R11 clear osc", {56'd0, ctl2_o}, {56'd0, 8'h40});
    wr(4'd15, 8'h10);
    chk("R11 no set", {62'd0, osc_stop_o, volt_low_o}, 64'd0);

    // calendar vectors: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(4'd14, VEC[i][119:112]);
      wr(4'd1, VEC[i][103:96]);
      wr(4'd2, VEC[i][95:88]);
      wr(4'd3, VEC[i][87:80]);
      wr(4'd4, VEC[i][79:72]);
      wr(4'd5, VEC[i][71:64]);
      wr(4'd6, VEC[i][63:56]);
      wr(4'd0, VEC[i][111:104]);
      pulse(PRESCALE);
      tests++;
      if (tod() !== {8'h00, VEC[i][55:0]}) begin
        fails++;
        $display("FAIL vector %0d (R2 R3 R4 R5 R6 R7) actual=%h expected=%h",
                 i, tod(), {8'h00, VEC[i][55:0]});
      end
    end

    // R8 masks and ignored address
    wr(4'd5, 8'hE5);
    chk("R8 month mask", {56'd0, mon_o}, {56'd0, 8'h85});
    wr(4'd3, 8'hF5);
    chk("R8 wday mask", {56'd0, wday_o}, {56'd0, 8'h05});
    snap = tod();
    wr(4'd7, 8'h33);
    chk("R8 ignored addr", tod(), snap);
    chk("R8 ignored ctl", {48'd0, ctl1_o, ctl2_o}, {48'd0, 8'h20, 8'h00});

    // R2 prescaler
    wr(4'd0, 8'h10);
    pulse(1);
    chk("R2 half second", {56'd0, sec_o}, {56'd0, 8'h10});
    pulse(1);
    chk("R2 full second", {56'd0, sec_o}, {56'd0, 8'h11});

    // R10 seconds write clears prescaler
    pulse(1);
    wr(4'd0, 8'h20);
    pulse(1);
    chk("R10 prescaler cleared", {56'd0, sec_o}, {56'd0, 8'h20});
    pulse(1);
    chk("R10 after clear", {56'd0, sec_o}, {56'd0, 8'h21});

    // R9 freeze holds, one pending second
    wr(4'd0, 8'h40);
    @(negedge clk); freeze = 1'b1;
    pulse(2 * PRESCALE);
    chk("R9 frozen", {56'd0, sec_o}, {56'd0, 8'h40});
    freeze = 1'b0;
    @(negedge clk);
    chk("R9 released", {56'd0, sec_o}, {56'd0, 8'h41});
    repeat (3) @(negedge clk);
    chk("R9 single pending", {56'd0, sec_o}, {56'd0, 8'h41});

    // R10 seconds write discards pending carry
    freeze = 1'b1;
    pulse(PRESCALE);
    wr(4'd0, 8'h30);
    freeze = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 pending discarded", {56'd0, sec_o}, {56'd0, 8'h30});

    // R9 write cycle defers a second
    wr(4'd0, 8'h05);
    pulse(PRESCALE - 1);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h22;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    s0 = sec_o;
    chk("R9 deferred", {48'd0, s0, min_o}, {48'd0, 8'h05, 8'h22});
    @(negedge clk);
    chk("R9 applied", {56'd0, sec_o}, {56'd0, 8'h06});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule